// File: doc/BRIEF.md
# Supervisor reset and watchdog controller

This block is the digital core of a processor supervisor. It turns three conditions into one reset for the processor: a low supply-good flag, a held push-button and a watchdog timeout. The supply-good flag comes already synchronized from an external comparator. The push-button input is active low. The watchdog is fed by falling edges on a strobe input, and a 2-bit select input picks its period. The block drives an active-high reset and its exact inverse.

All timing is counted in pulses of a 1 ms tick input. When the cause of a reset goes away, reset is held for a stretch of ticks before it is released. The button is debounced by requiring it to stay low for a run of consecutive ticks. The watchdog has no disable. It is frozen and cleared while reset is active, and it restarts from zero when reset is released.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `supply_ok_i` is low, `rst_o` is 1. It rises on the clock edge after `supply_ok_i` is first sampled low.
- R2: After `supply_ok_i` returns high, `rst_o` stays 1 through the next HOLD_MS tick pulses. It drops on the edge of tick number HOLD_MS+1.
- R3: If the synchronized button input stays low for DEB_MS consecutive ticks, `rst_o` goes to 1 and stays 1 while the button is held. Once the button is high again, the R2 stretch of HOLD_MS+1 ticks applies.
- R4: A low pulse on the button that lasts fewer than DEB_MS ticks causes no reset. A single high sample clears the debounce count.
- R5: `wd_sel_i` picks the watchdog period: 00 selects P0_MS, 01 selects P1_MS, and both 10 and 11 select P2_MS. If no strobe edge arrives, the count reaches the period on tick number P ms after release. `rst_o` then rises on the following clock edge.
- R6: Only a high-to-low transition of the synchronized `strobe_i` restarts the watchdog count. A level held low or a rising edge has no effect on when it expires.
- R7: After a watchdog timeout, `rst_o` stays 1 for HOLD_MS more ticks and drops on tick HOLD_MS+1. The watchdog count then starts again from zero.
- R8: Strobe edges that occur while reset is active have no effect. After release, the next expiry comes a full period later.
- R9: No value of `wd_sel_i` and no other input setting disables the watchdog. Every select code leads to a timeout.
- R10: `rst_no` is always the exact inverse of `rst_o`.
- R11: While `rst_ni` is low, `rst_o` is 1 and `rst_no` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 ms timebase pulse, one clock wide |
| supply_ok_i | input | 1 | Synchronized supply-good flag |
| btn_ni | input | 1 | Push-button input, active low, asynchronous |
| strobe_i | input | 1 | Watchdog strobe, falling edge restarts the count, asynchronous |
| wd_sel_i | input | 2 | Watchdog period select |
| rst_o | output | 1 | Reset to the processor, active high |
| rst_no | output | 1 | Reset to the processor, active low |

## Verification
The bench builds the block with HOLD_MS=6, DEB_MS=4 and watchdog periods of 10, 14 and 20 ticks, and issues one tick every four clocks. With these short values every select code can be driven into timeout, and each stretch can be followed to its exact releasing tick within a few thousand cycles. The gaps between ticks are wide enough that the two-flop synchronizer settles before the next tick. This lets strobe and button edges be placed so the tick of each expiry and release can be predicted exactly.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    WD_SHORT = 2'b00,
    WD_MID   = 2'b01,
    WD_LONG  = 2'b10,
    WD_LONG2 = 2'b11
  } wd_sel_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g] <= RST_VAL[g];
        s2_q[g] <= RST_VAL[g];
      end else begin
        s1_q[g] <= d_i[g];
        s2_q[g] <= s1_q[g];
      end
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
  parameter int unsigned DEB_MS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic btn_s_i,   // synchronized, active low
  output logic pressed_o
);
  localparam int unsigned CW = $clog2(DEB_MS + 1);
  localparam logic [CW-1:0] DEB_C = CW'(DEB_MS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (btn_s_i)                    cnt_q <= '0;
    else if (tick_i && cnt_q != DEB_C)   cnt_q <= cnt_q + 1'b1;
  end

  assign pressed_o = (cnt_q == DEB_C);
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
  import sup_pkg::*;
#(
  parameter int unsigned P0_MS = 150,
  parameter int unsigned P1_MS = 610,
  parameter int unsigned P2_MS = 1200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       stb_s_i,
  input  logic [1:0] sel_i,
  input  logic       hold_i,   // reset active: freeze and clear
  output logic       expire_o
);
  localparam int unsigned PMAX = max3(P0_MS, P1_MS, P2_MS);
  localparam int unsigned CW   = $clog2(PMAX + 1);

  logic [CW-1:0] cnt_q, limit;
  logic          stb_q, fall;
  wd_sel_e       sel;

  assign sel  = wd_sel_e'(sel_i);
  assign fall = stb_q & ~stb_s_i;

  always_comb begin
    unique case (sel)
      WD_SHORT: limit = CW'(P0_MS);
      WD_MID:   limit = CW'(P1_MS);
      default:  limit = CW'(P2_MS);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      stb_q <= stb_s_i;
      if (hold_i || fall)                 cnt_q <= '0;
      else if (tick_i && cnt_q < limit)   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = !hold_i && (cnt_q >= limit);
endmodule

// File: rtl/sup_hold.sv
module sup_hold #(
  parameter int unsigned HOLD_MS = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cause_i,
  output logic rst_o
);
  localparam int unsigned CW = $clog2(HOLD_MS + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD_MS);

  logic [CW-1:0] cnt_q;
  logic          rst_q;

  // release on tick HOLD_MS+1 so a partial first tick never shortens the stretch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (cause_i) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (rst_q && tick_i) begin
      if (cnt_q == HOLD_C) begin
        rst_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_o = rst_q;
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int unsigned HOLD_MS = 250,
  parameter int unsigned DEB_MS  = 16,
  parameter int unsigned P0_MS   = 150,
  parameter int unsigned P1_MS   = 610,
  parameter int unsigned P2_MS   = 1200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       supply_ok_i,
  input  logic       btn_ni,
  input  logic       strobe_i,
  input  logic [1:0] wd_sel_i,
  output logic       rst_o,
  output logic       rst_no
);
  logic [1:0] raw, syn;
  logic       btn_pressed, wd_expire, rst_q, cause;

  assign raw = {strobe_i, btn_ni};

  sup_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  sup_debounce #(.DEB_MS(DEB_MS)) u_deb (
    .clk_i, .rst_ni, .tick_i, .btn_s_i(syn[0]), .pressed_o(btn_pressed)
  );

  sup_watchdog #(.P0_MS(P0_MS), .P1_MS(P1_MS), .P2_MS(P2_MS)) u_wd (
    .clk_i, .rst_ni, .tick_i, .stb_s_i(syn[1]), .sel_i(wd_sel_i),
    .hold_i(rst_q), .expire_o(wd_expire)
  );

  assign cause = !supply_ok_i || btn_pressed || wd_expire;

  sup_hold #(.HOLD_MS(HOLD_MS)) u_hold (
    .clk_i, .rst_ni, .tick_i, .cause_i(cause), .rst_o(rst_q)
  );

  assign rst_o  = rst_q;
  assign rst_no = ~rst_q;
endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic supply_ok_i,
  input logic rst_o,
  input logic rst_no,
  input logic btn_pressed,
  input logic wd_expire
);
  a_r1_supply_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> rst_o);

  a_r2_release_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> $past(tick_i) && $past(supply_ok_i));

  a_r2_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o && !tick_i |=> rst_o);

  a_r3_button_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btn_pressed |=> rst_o);

  a_r5_expiry_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire |=> rst_o);

  a_r8_frozen_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> !wd_expire);

  a_r10_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_no == !rst_o);
endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .supply_ok_i(supply_ok_i),
  .rst_o(rst_o), .rst_no(rst_no), .btn_pressed(btn_pressed), .wd_expire(wd_expire)
);

// File: tb/test_sup_reset_ctrl.sv
`timescale 1ns/1ps
module test_sup_reset_ctrl;
  localparam int HOLD = 6;
  localparam int DEB  = 4;
  localparam int P0   = 10;
  localparam int P1   = 14;
  localparam int P2   = 20;

  // {select, expected period in ticks}
  localparam logic [9:0] VEC [4] = '{
    {2'b00, 8'd10}, {2'b01, 8'd14}, {2'b10, 8'd20}, {2'b11, 8'd20}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       supply_ok_i = 1'b0;
  logic       btn_ni = 1'b1;
  logic       strobe_i = 1'b1;
  logic [1:0] wd_sel_i = 2'b00;
  logic       rst_o, rst_no;
  logic [1:0] tdiv = 2'd0;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  sup_reset_ctrl #(.HOLD_MS(HOLD), .DEB_MS(DEB), .P0_MS(P0), .P1_MS(P1), .P2_MS(P2)) i_sup_reset_ctrl (
    .clk_i, .rst_ni, .tick_i, .supply_ok_i, .btn_ni, .strobe_i, .wd_sel_i, .rst_o, .rst_no
  );

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    tdiv   <= tdiv + 2'd1;
    tick_i <= (tdiv == 2'd3);
  end

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk_i);
      if (tick_i) k++;
    end
    @(negedge clk_i);
  endtask

  task automatic chk(input logic exp, input string req);
    n_run++;
    if (rst_o !== exp || rst_no !== ~exp) begin
      n_fail++;
      $display("FAIL %s: rst_o=%b rst_no=%b expected rst_o=%b rst_no=%b",
               req, rst_o, rst_no, exp, ~exp);
    end
  endtask

  task automatic after_expiry();
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(1'b1, "R11");
    rst_ni = 1'b1;

    // table: power cycle, stretch, then timeout for each select code
    for (int v = 0; v < 4; v++) begin
      wd_sel_i    = VEC[v][9:8];
      supply_ok_i = 1'b0;
      wait_ticks(1);
      chk(1'b1, "R1");
      supply_ok_i = 1'b1;
      wait_ticks(HOLD);
      chk(1'b1, "R2");
      wait_ticks(1);
      chk(1'b0, "R2");
      wait_ticks(int'(VEC[v][7:0]) - 1);
      chk(1'b0, "R5");
      wait_ticks(1);
      after_expiry();
      chk(1'b1, "R5 R9");
    end

    // R7: stretch after timeout, count restarts from zero
    wd_sel_i = 2'b00;
    wait_ticks(HOLD);
    chk(1'b1, "R7");
    wait_ticks(1);
    chk(1'b0, "R7");

    // R6: falling edge restarts, rising edge does not
    wait_ticks(3);
    strobe_i = 1'b0;
    wait_ticks(5);
    strobe_i = 1'b1;
    wait_ticks(4);
    chk(1'b0, "R6");
    wait_ticks(1);
    after_expiry();
    chk(1'b1, "R6");

    // R8: strobe edges during reset ignored
    wait_ticks(1);
    strobe_i = 1'b0;
    wait_ticks(1);
    strobe_i = 1'b1;
    wait_ticks(1);
    strobe_i = 1'b0;
    wait_ticks(3);
    chk(1'b1, "R8");
    wait_ticks(1);
    chk(1'b0, "R7");
    wait_ticks(P0 - 1);
    chk(1'b0, "R8");
    wait_ticks(1);
    after_expiry();
    chk(1'b1, "R8");

    // R4: short button pulse ignored
    wait_ticks(HOLD + 1);
    chk(1'b0, "R7");
    btn_ni = 1'b0;
    wait_ticks(DEB - 2);
    btn_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(1'b0, "R4");

    // refresh watchdog, then R3: long press
    strobe_i = 1'b1;
    wait_ticks(1);
    strobe_i = 1'b0;
    btn_ni = 1'b0;
    wait_ticks(DEB + 2);
    chk(1'b1, "R3");
    wait_ticks(20);
    chk(1'b1, "R3");
    btn_ni = 1'b1;
    wait_ticks(HOLD);
    chk(1'b1, "R3");
    wait_ticks(1);
    chk(1'b0, "R3");

    // R11: reset input asserts outputs
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(1'b1, "R11");
    rst_ni = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule